// File: doc/BRIEF.md
# Per-Line Audio Sample Pacer

This block runs once per video scan line. It decides how many stereo audio samples the line's audio data packet should carry, and it takes those samples from a sample FIFO. A credit accumulator in unsigned fixed point, with 16 fractional bits, converts the ratio of audio rate to line rate into whole samples.

- At each accepted line start the per-line increment is added to the accumulator.
- Whole samples are then granted, up to the packet capacity of four.
- The grant is also limited by how many samples the FIFO holds.
- Any credit left over stays in the accumulator for later lines.

For example, 48 kHz audio over a 31.5 kHz line rate uses an increment of about 1.524. The pacer then grants one or two samples per line. The per-line capacity of four covers audio rates up to about 96 kHz.

After the decision, the block issues one FIFO read strobe per granted sample, on consecutive cycles. It also keeps a published word that other agents can read. The word combines a wrapping tail pointer with an 8-bit sequence counter, and both advance once per read.

Top module: `audio_line_pacer`

## Requirements
- R1: After reset, `grant_valid`, `grant_count`, `rd_strobe` and `ptr_word` are all zero, and the accumulator holds zero credit.
- R2: An accepted `line_start` adds `incr` (unsigned, 16 fractional bits) to the accumulator. The grant is the integer part of the sum, capped at 4. The granted whole units are subtracted, and any fractional or excess credit is kept.
- R3: The grant never exceeds `fifo_level` as sampled at the accepted line start. Credit that is not used because of this limit stays in the accumulator.
- R4: Credit kept after a decision is capped at 4.0 samples. Any excess is discarded.
- R5: `grant_valid` is high for exactly the one cycle after an accepted `line_start`. In that cycle `grant_count` shows the grant, and it holds that value until the next decision.
- R6: `rd_strobe` is high for exactly `grant_count` consecutive cycles, starting in the cycle after the accepted `line_start`.
- R7: `ptr_word` is {sequence[7:0], tail[5:0]}. Each read strobe advances the tail by one modulo 64 and the sequence by one modulo 256. The new word is visible from the cycle after the strobe, and the word is stable in cycles without a strobe.
- R8: A `line_start` that arrives while read strobes are still pending is ignored. It produces no grant, and it changes neither the accumulator nor `ptr_word`.
- R9: Over many lines with enough samples in the FIFO, the total number of samples granted is within one of floor(lines × incr / 65536).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each scan line |
| incr | input | 19 | Samples per line, 3 integer and 16 fractional bits |
| fifo_level | input | 7 | Number of samples currently held in the FIFO |
| grant_valid | output | 1 | Pulses in the cycle after a line decision |
| grant_count | output | 3 | Samples granted for this line's packet (0 to 4) |
| rd_strobe | output | 1 | FIFO read strobe, one per granted sample |
| ptr_word | output | 14 | Published word: sequence counter over tail pointer |

## Verification
A sequential vector walk from reset covers several line patterns:
- a fractional increment that alternates one and two samples, which shows that remainders are carried;
- an empty or short FIFO with credit left over, which separates clipping from losing credit;
- a large increment into an empty FIFO, which exposes the credit cap;
- a back-to-back full grant of four, which checks the capacity limit.

A line start injected while strobes are still running is followed by a probe line. The probe line's grant shows whether the ignored increment leaked into the accumulator. A 400-line run at the 48 kHz ratio compares the cumulative count with the ideal product. The tail and sequence fields both wrap during this run.

// File: rtl/alp_pkg.sv
package alp_pkg;

    // Packet capacity in stereo samples per line.
    localparam int ALP_MAX_GRANT = 4;

    // Smaller of two unsigned counts, each at most 32 bits.
    function automatic logic [31:0] alp_min(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/alp_credit.sv
module alp_credit #(
    parameter int FRAC_W    = 16,
    parameter int INCR_W    = 19,
    parameter int LVL_W     = 7,
    parameter int MAX_GRANT = alp_pkg::ALP_MAX_GRANT,
    parameter int CNT_W     = $clog2(MAX_GRANT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [INCR_W-1:0] incr,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic [CNT_W-1:0]  grant_now,
    output logic              grant_valid,
    output logic [CNT_W-1:0]  grant_count
);
    localparam int ACC_W   = INCR_W;
    localparam int SUM_W   = INCR_W + 1;
    localparam int WHOLE_W = SUM_W - FRAC_W;
    localparam logic [SUM_W-1:0] SAT = SUM_W'(MAX_GRANT) << FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             vld;
        logic [CNT_W-1:0] cnt;
    } credit_t;

    credit_t st_d, st_q;

    logic [SUM_W-1:0]   sum;
    logic [WHOLE_W-1:0] whole;
    logic [SUM_W-1:0]   rem;
    logic [31:0]        want, have, give;

    always_comb begin
        sum   = {1'b0, st_q.acc} + {1'b0, incr};
        whole = sum[SUM_W-1:FRAC_W];
        want  = alp_pkg::alp_min(32'(whole), 32'(MAX_GRANT));
        have  = alp_pkg::alp_min(32'(fifo_level), 32'(MAX_GRANT));
        give  = alp_pkg::alp_min(want, have);
        grant_now = take ? CNT_W'(give) : '0;
        rem   = sum - (SUM_W'(give) << FRAC_W);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.cnt = CNT_W'(give);
            st_d.acc = (rem > SAT) ? ACC_W'(SAT) : rem[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.vld;
    assign grant_count = st_q.cnt;

    // R4: stored credit never exceeds the cap
    p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.acc} <= SAT);
    // R2: a grant never exceeds the packet capacity
    p_grant_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(grant_count) <= 32'(MAX_GRANT));
    // R3: a grant never exceeds the FIFO level seen at the decision
    p_fifo_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> 32'(grant_count) <= 32'($past(fifo_level)));
endmodule

// File: rtl/alp_reader.sv
module alp_reader #(
    parameter int CNT_W = 3,
    parameter int PTR_W = 6,
    parameter int SEQ_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [CNT_W-1:0]       load_cnt,
    output logic                   busy,
    output logic                   rd_strobe,
    output logic [SEQ_W+PTR_W-1:0] ptr_word
);
    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic [PTR_W-1:0] tail;
        logic [SEQ_W-1:0] seq;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
            st_d.tail = st_q.tail + 1'b1;
            st_d.seq  = st_q.seq + 1'b1;
        end
        if (load) st_d.left = load_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = (st_q.left != '0);
    assign rd_strobe = busy;
    assign ptr_word  = {st_q.seq, st_q.tail};

    // R7: each strobe advances the tail by one
    p_tail_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> ptr_word[PTR_W-1:0] == $past(ptr_word[PTR_W-1:0]) + 1'b1);
    // R7: each strobe advances the sequence counter by one
    p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> ptr_word[SEQ_W+PTR_W-1:PTR_W] == $past(ptr_word[SEQ_W+PTR_W-1:PTR_W]) + 1'b1);
    // R7: the word is stable without a strobe
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(ptr_word));
endmodule

// File: rtl/audio_line_pacer.sv
module audio_line_pacer #(
    parameter int FRAC_W    = 16,
    parameter int INCR_W    = 19,
    parameter int PTR_W     = 6,
    parameter int SEQ_W     = 8,
    parameter int MAX_GRANT = alp_pkg::ALP_MAX_GRANT,
    parameter int LVL_W     = PTR_W + 1,
    parameter int CNT_W     = $clog2(MAX_GRANT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_start,
    input  logic [INCR_W-1:0]      incr,
    input  logic [LVL_W-1:0]       fifo_level,
    output logic                   grant_valid,
    output logic [CNT_W-1:0]       grant_count,
    output logic                   rd_strobe,
    output logic [SEQ_W+PTR_W-1:0] ptr_word
);
    logic             busy;
    logic             take;
    logic [CNT_W-1:0] grant_now;

    assign take = line_start && !busy;

    alp_credit #(
        .FRAC_W(FRAC_W), .INCR_W(INCR_W), .LVL_W(LVL_W),
        .MAX_GRANT(MAX_GRANT), .CNT_W(CNT_W)
    ) u_credit (
        .clk(clk), .rst_n(rst_n), .take(take), .incr(incr),
        .fifo_level(fifo_level), .grant_now(grant_now),
        .grant_valid(grant_valid), .grant_count(grant_count)
    );

    alp_reader #(
        .CNT_W(CNT_W), .PTR_W(PTR_W), .SEQ_W(SEQ_W)
    ) u_reader (
        .clk(clk), .rst_n(rst_n), .load(take), .load_cnt(grant_now),
        .busy(busy), .rd_strobe(rd_strobe), .ptr_word(ptr_word)
    );

    // R8: a line start during pending reads yields no decision
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && rd_strobe) |=> !grant_valid);
    // R6: a decision with a nonzero grant starts strobing at once
    p_strobe_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_count != '0) |-> rd_strobe);
    // R5: grant count only changes together with a decision pulse
    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |=> (grant_valid || $stable(grant_count)));
endmodule

// File: tb/audio_line_pacer_test.sv
module audio_line_pacer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [18:0] incr = '0;
    logic [6:0]  fifo_level = '0;
    logic        grant_valid;
    logic [2:0]  grant_count;
    logic        rd_strobe;
    logic [13:0] ptr_word;

    int checks = 0;
    int fails  = 0;
    int total  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    audio_line_pacer uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .incr(incr),
        .fifo_level(fifo_level), .grant_valid(grant_valid),
        .grant_count(grant_count), .rd_strobe(rd_strobe), .ptr_word(ptr_word)
    );

    // {incr, fifo_level, expected grant}, walked in order from reset (R2, R3, R4)
    localparam logic [18:0] V_INC [10] = '{19'h18000, 19'h18000, 19'h10000, 19'h10000,
        19'h30000, 19'h08000, 19'h70000, 19'h00000, 19'h60000, 19'h00000};
    localparam logic [6:0] V_LVL [10] = '{7'd10, 7'd10, 7'd0, 7'd1, 7'd10, 7'd10, 7'd0,
        7'd10, 7'd10, 7'd2};
    localparam int V_EXP [10] = '{1, 2, 0, 1, 4, 0, 0, 4, 4, 2};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    // Runs one line; returns granted count and counted strobes.
    task automatic run_line(input logic [18:0] inc, input logic [6:0] lvl,
                            input bit quiet, output int got, output int strobes);
        @(negedge clk);
        incr = inc; fifo_level = lvl; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        got = int'(grant_count);
        strobes = 0;
        if (!quiet) check(grant_valid == 1'b1, "R5 pulse", int'(grant_valid), 1);
        for (int k = 0; k < 6; k++) begin
            if (rd_strobe) begin
                strobes++;
                if (!quiet) check(k < got, "R6 strobe window", k, got);
            end
            if (k > 0 && !quiet) check(grant_valid == 1'b0, "R5 single pulse", int'(grant_valid), 0);
            @(negedge clk);
        end
        total += strobes;
    endtask

    initial begin
        int got, st;
        longint ideal;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(grant_valid == 0, "R1 grant_valid", int'(grant_valid), 0);
        check(grant_count == 0, "R1 grant_count", int'(grant_count), 0);
        check(rd_strobe == 0, "R1 rd_strobe", int'(rd_strobe), 0);
        check(ptr_word == 0, "R1 ptr_word", int'(ptr_word), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R6 R7: vector walk
        for (int i = 0; i < 10; i++) begin
            run_line(V_INC[i], V_LVL[i], 1'b0, got, st);
            check(got == V_EXP[i], "R2/R3/R4 grant", got, V_EXP[i]);
            check(st == V_EXP[i], "R6 strobe count", st, V_EXP[i]);
            check(ptr_word == {8'(total), 6'(total)}, "R7 ptr_word", int'(ptr_word),
                  int'({8'(total), 6'(total)}));
        end

        // R8: line start during pending reads is ignored
        @(negedge clk);
        incr = 19'h40000; fifo_level = 7'd10; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        check(grant_count == 4, "R8 setup grant", int'(grant_count), 4);
        @(negedge clk);
        incr = 19'h30000; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        check(grant_valid == 0, "R8 no decision", int'(grant_valid), 0);
        repeat (4) @(negedge clk);
        total += 4;
        check(ptr_word == {8'(total), 6'(total)}, "R8 ptr_word", int'(ptr_word),
              int'({8'(total), 6'(total)}));
        run_line(19'h08000, 7'd10, 1'b0, got, st);
        check(got == 0, "R8 credit untouched", got, 0);

        // R9: long run at the 48 kHz / 31.5 kHz ratio, wraps tail and sequence
        total = 0;
        for (int n = 0; n < 400; n++) begin
            run_line(19'd99864, 7'd64, 1'b1, got, st);
        end
        ideal = (longint'(400) * 99864) / 65536;
        check((longint'(total) >= ideal - 1) && (longint'(total) <= ideal + 1),
              "R9 long-run total", total, int'(ideal));
        total += 22; // samples granted before the long run (18 + 4)
        check(ptr_word == {8'(total), 6'(total)}, "R7 wrap ptr_word", int'(ptr_word),
              int'({8'(total), 6'(total)}));

        finish_run();
    end
endmodule